// File: doc/BRIEF.md
# Processor Status Word Unit

This block keeps the processor status word. It has five condition flags, which change only when an ALU result arrives. It also has two control bits: interrupt enable and supervisor mode. When the ALU presents a result with its valid strobe, the block registers four flags from that result. Sign and zero are derived from the result value. Carry and overflow are copied from the ALU's own indications. An equal flag reports whether the new result matches the result accepted just before it. The branch unit reads the flags as separate pins, or as one packed word.

The two control bits can be written through a privileged port, but only while supervisor mode is set. A write attempted in user mode changes nothing and raises a one-cycle violation pulse. Interrupt entry saves both control bits, clears interrupt enable and enters supervisor mode. Return from interrupt restores the saved pair. No path exists for software to load the condition flags directly.

Top module: `psw_unit`

## Requirements
- R1: After a synchronous active-low reset, `status_word` reads 8'h40: supervisor set, and interrupt enable and all flags clear. `priv_violation` is low.
- R2: In the cycle after `res_valid`, `flag_sign` equals the most significant bit of the accepted result.
- R3: In the cycle after `res_valid`, `flag_zero` is 1 exactly when every bit of the accepted result is 0.
- R4: In the cycle after `res_valid`, `flag_carry` and `flag_ovf` hold the `res_carry` and `res_ovf` values presented with that result.
- R5: `flag_equal` is 1 when the accepted result equals the result accepted before it. The first result after reset always gives 0, and only the immediately preceding result counts.
- R6: When `res_valid` is low, all five condition flags keep their values.
- R7: In supervisor mode, `priv_wr` loads `priv_wdata[0]` into interrupt enable and `priv_wdata[1]` into supervisor in the next cycle. The condition flags are untouched.
- R8: A `priv_wr` in user mode, with no interrupt event in the same cycle, leaves both control bits unchanged. It drives `priv_violation` high for exactly the next cycle.
- R9: `irq_enter` saves the pair {supervisor, interrupt enable}. In the next cycle interrupt enable is 0 and supervisor is 1.
- R10: `irq_return` restores interrupt enable and supervisor from the saved pair.
- R11: Priority is `irq_enter` over `irq_return` over `priv_wr`. A write that loses to an interrupt event is dropped without a violation pulse.
- R12: `status_word` bit layout: 0 carry, 1 zero, 2 sign, 3 overflow, 4 equal, 5 interrupt enable, 6 supervisor, 7 always 0. The individual flag pins match these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | ALU result valid strobe |
| res_value | input | DATA_W | ALU result |
| res_carry | input | 1 | ALU carry-out for this result |
| res_ovf | input | 1 | ALU signed overflow for this result |
| priv_wr | input | 1 | Privileged control write request |
| priv_wdata | input | 2 | Bit 1 supervisor, bit 0 interrupt enable |
| irq_enter | input | 1 | Interrupt entry event |
| irq_return | input | 1 | Return from interrupt event |
| status_word | output | 8 | Packed status word (R12 layout) |
| flag_sign | output | 1 | Sign flag |
| flag_zero | output | 1 | Zero flag |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag |
| flag_equal | output | 1 | Equal flag |
| int_en | output | 1 | Interrupt enable |
| sup_mode | output | 1 | Supervisor mode |
| priv_violation | output | 1 | One-cycle pulse on a refused write |

## Verification
The bench runs the same result twice in a row, and also a result that matches the one two steps back. An equal flag that compares against the wrong history, or that fires on the first result after reset, fails these checks. It tries a control write from user mode and looks for both an unchanged word and a pulse that lasts exactly one cycle. A missing privilege guard would let the write through, and a stuck pulse would be seen in the second cycle. It raises all three control events at once and then return plus write together. A wrong priority order leaves the mode bits in the wrong state. The word is compared with the separate pins to catch a bit placed in the wrong position.

// File: rtl/psw_pkg.sv
// Shared types for the status word unit.
// Assumes: condition flags packed with carry in the lowest bit.
package psw_pkg;
    typedef struct packed {
        logic equal;
        logic ovf;
        logic sign;
        logic zero;
        logic carry;
    } cond_flags_t;

    localparam int FLAG_BITS = $bits(cond_flags_t);
    localparam int WORD_W    = 8;
endpackage

// File: rtl/psw_flag_gen.sv
// Condition flag generator: registers sign, zero, carry, overflow and equal
// from each valid ALU result and keeps the previous result for the equal test.
// Assumes: res_carry/res_ovf are aligned with res_value in the same cycle.
module psw_flag_gen #(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      res_valid,
    input  logic [DATA_W-1:0]         res_value,
    input  logic                      res_carry,
    input  logic                      res_ovf,
    output psw_pkg::cond_flags_t      flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0]    prev_res;
    logic                 prev_seen;
    psw_pkg::cond_flags_t next_flags;

    // Form the flag set the current result would produce.
    always_comb begin
        next_flags.sign  = res_value[MSB];
        next_flags.zero  = (res_value == '0);
        next_flags.carry = res_carry;
        next_flags.ovf   = res_ovf;
        next_flags.equal = prev_seen && (res_value == prev_res);
    end

    // Capture flags and result history on each valid result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags     <= '0;
            prev_res  <= '0;
            prev_seen <= 1'b0;
        end else if (res_valid) begin
            flags     <= next_flags;
            prev_res  <= res_value;
            prev_seen <= 1'b1;
        end
    end

    AST_SIGN_TRACKS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> flags.sign == $past(res_value[MSB])); // R2
    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        flags.zero |-> !flags.sign); // R3
    AST_CARRY_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> flags.carry == $past(res_carry) && flags.ovf == $past(res_ovf)); // R4
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(flags)); // R6
endmodule

// File: rtl/psw_mode_ctrl.sv
// Control bit keeper: interrupt enable and supervisor mode, one saved copy
// for interrupt nesting depth one, and the privileged write guard.
// Assumes: event priority irq_enter > irq_return > priv_wr.
module psw_mode_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       priv_wr,
    input  logic [1:0] priv_wdata,
    input  logic       irq_enter,
    input  logic       irq_return,
    output logic       int_en,
    output logic       sup_mode,
    output logic       priv_violation
);
    logic saved_ie;
    logic saved_sup;
    logic irq_event;
    logic refused;

    // Decode whether an event is present and whether a write is refused.
    always_comb begin
        irq_event = irq_enter || irq_return;
        refused   = priv_wr && !sup_mode && !irq_event;
    end

    // Update the control pair in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en    <= 1'b0;
            sup_mode  <= 1'b1;
            saved_ie  <= 1'b0;
            saved_sup <= 1'b1;
        end else if (irq_enter) begin
            saved_ie  <= int_en;
            saved_sup <= sup_mode;
            int_en    <= 1'b0;
            sup_mode  <= 1'b1;
        end else if (irq_return) begin
            int_en    <= saved_ie;
            sup_mode  <= saved_sup;
        end else if (priv_wr && sup_mode) begin
            int_en    <= priv_wdata[0];
            sup_mode  <= priv_wdata[1];
        end
    end

    // Register the violation pulse for a refused write.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_violation <= 1'b0;
        else        priv_violation <= refused;
    end

    AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        priv_wr && !sup_mode && !irq_enter && !irq_return
        |=> $stable(int_en) && $stable(sup_mode) && priv_violation); // R8
    AST_ENTER_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> sup_mode && !int_en); // R9
    AST_EVENT_NO_VIOLATION: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enter || irq_return) |=> !priv_violation); // R11
endmodule

// File: rtl/psw_unit.sv
// Status word unit top: joins the flag generator and control bit keeper
// and packs the word (bit 7 reads 0).
// Assumes: single clock, synchronous active-low reset.
module psw_unit #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_value,
    input  logic              res_carry,
    input  logic              res_ovf,
    input  logic              priv_wr,
    input  logic [1:0]        priv_wdata,
    input  logic              irq_enter,
    input  logic              irq_return,
    output logic [7:0]        status_word,
    output logic              flag_sign,
    output logic              flag_zero,
    output logic              flag_carry,
    output logic              flag_ovf,
    output logic              flag_equal,
    output logic              int_en,
    output logic              sup_mode,
    output logic              priv_violation
);
    psw_pkg::cond_flags_t flags;

    psw_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_value (res_value),
        .res_carry (res_carry),
        .res_ovf   (res_ovf),
        .flags     (flags)
    );

    psw_mode_ctrl u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .priv_wr        (priv_wr),
        .priv_wdata     (priv_wdata),
        .irq_enter      (irq_enter),
        .irq_return     (irq_return),
        .int_en         (int_en),
        .sup_mode       (sup_mode),
        .priv_violation (priv_violation)
    );

    // Pack the word and fan out the individual flag pins.
    always_comb begin
        status_word = {1'b0, sup_mode, int_en, flags};
        flag_sign   = flags.sign;
        flag_zero   = flags.zero;
        flag_carry  = flags.carry;
        flag_ovf    = flags.ovf;
        flag_equal  = flags.equal;
    end

    AST_PRIV_WRITE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        priv_wr && !res_valid |=> $stable(status_word[4:0])); // R7
endmodule

// File: tb/psw_unit_bench.sv
module psw_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_value = '0;
    logic        res_carry = 1'b0;
    logic        res_ovf = 1'b0;
    logic        priv_wr = 1'b0;
    logic [1:0]  priv_wdata = '0;
    logic        irq_enter = 1'b0;
    logic        irq_return = 1'b0;
    logic [7:0]  status_word;
    logic        flag_sign, flag_zero, flag_carry, flag_ovf, flag_equal;
    logic        int_en, sup_mode, priv_violation;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psw_unit #(.DATA_W(16)) u_psw_unit (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
        .res_carry(res_carry), .res_ovf(res_ovf), .priv_wr(priv_wr),
        .priv_wdata(priv_wdata), .irq_enter(irq_enter), .irq_return(irq_return),
        .status_word(status_word), .flag_sign(flag_sign), .flag_zero(flag_zero),
        .flag_carry(flag_carry), .flag_ovf(flag_ovf), .flag_equal(flag_equal),
        .int_en(int_en), .sup_mode(sup_mode), .priv_violation(priv_violation)
    );

    // {value, carry, ovf, expected flags {equal, ovf, sign, zero, carry}}
    localparam logic [22:0] VEC [0:7] = '{
        {16'h0000, 1'b0, 1'b0, 5'b00010},
        {16'h0000, 1'b1, 1'b0, 5'b10011},
        {16'h8000, 1'b0, 1'b1, 5'b01100},
        {16'h8000, 1'b0, 1'b0, 5'b10100},
        {16'h7FFF, 1'b1, 1'b1, 5'b01001},
        {16'h0001, 1'b0, 1'b0, 5'b00000},
        {16'hFFFF, 1'b1, 1'b0, 5'b00101},
        {16'h0001, 1'b0, 1'b0, 5'b00000}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R12: pins must mirror word bits
    task automatic check_pins();
        check("R12", {1'b0, sup_mode, int_en, flag_equal, flag_ovf, flag_sign, flag_zero, flag_carry},
              status_word);
    endtask

    task automatic apply_result(input logic [15:0] v, input logic c, input logic o);
        @(negedge clk);
        res_value = v; res_carry = c; res_ovf = o; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic ctrl_cycle(input logic wr, input logic [1:0] wd, input logic ent, input logic ret);
        @(negedge clk);
        priv_wr = wr; priv_wdata = wd; irq_enter = ent; irq_return = ret;
        @(negedge clk);
        priv_wr = 1'b0; irq_enter = 1'b0; irq_return = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", status_word, 8'h40);
        check("R1", {7'b0, priv_violation}, 8'h00);
        check_pins();

        // R2 R3 R4 R5: vector table walk
        for (int i = 0; i < 8; i++) begin
            apply_result(VEC[i][22:7], VEC[i][6], VEC[i][5]);
            check("R2/R3/R4/R5", status_word, {3'b010, VEC[i][4:0]});
            check_pins();
        end

        // R6: flags hold with no valid result
        apply_result(16'h9000, 1'b1, 1'b0);
        check("R2", status_word, 8'h45);
        @(negedge clk); res_value = 16'h0000; res_carry = 1'b0;
        repeat (3) @(negedge clk);
        check("R6", status_word, 8'h45);

        // R7: supervisor write sets ie, keeps flags
        ctrl_cycle(1'b1, 2'b11, 1'b0, 1'b0);
        check("R7", status_word, 8'h65);
        ctrl_cycle(1'b1, 2'b01, 1'b0, 1'b0);
        check("R7", status_word, 8'h25);

        // R8: user write ignored, one-cycle pulse
        @(negedge clk);
        priv_wr = 1'b1; priv_wdata = 2'b11;
        @(negedge clk);
        priv_wr = 1'b0;
        check("R8", status_word, 8'h25);
        check("R8", {7'b0, priv_violation}, 8'h01);
        @(negedge clk);
        check("R8", {7'b0, priv_violation}, 8'h00);

        // R9 R10: enter and return
        ctrl_cycle(1'b0, 2'b00, 1'b1, 1'b0);
        check("R9", status_word, 8'h45);
        ctrl_cycle(1'b0, 2'b00, 1'b0, 1'b1);
        check("R10", status_word, 8'h25);

        // R11: enter beats return and write, no violation
        ctrl_cycle(1'b1, 2'b10, 1'b1, 1'b1);
        check("R11", status_word, 8'h45);
        check("R11", {7'b0, priv_violation}, 8'h00);
        // R11: return beats supervisor write
        ctrl_cycle(1'b1, 2'b00, 1'b0, 1'b1);
        check("R11", status_word, 8'h25);
        check_pins();

        // R1 R5: mid-run reset, then equal clear on first result
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1", status_word, 8'h40);
        apply_result(16'h0000, 1'b0, 1'b0);
        check("R5", status_word, 8'h42);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule